// File: doc/BRIEF.md
# Prioritized Interrupt Status Aggregator

This block collects level-sensitive interrupt requests from three downstream devices and from the host bridge core. Each request is captured into a sticky status bit when its level rises. A per-source enable register masks the status bits to form a pending vector. The OR of that vector drives one level-sensitive interrupt line towards the processor side.

The sources sit at fixed positions in a five-bit vector. Devices 0, 1 and 2 use bits 0 to 2, the bridge core uses bit 4, and bit 3 is reserved. Service is requested with a one-cycle `svc_req` strobe. A three-state machine then reports the highest-priority pending source, or flags the request as spurious when nothing is pending.

The service machine has three states:
- **IDLE** waits for a request.
- **GRANT** presents the chosen index for one cycle.
- **SPUR** presents the spurious flag for one cycle.

It has four transitions:
- **IDLE→GRANT**: a request arrives while something is pending.
- **IDLE→SPUR**: a request arrives while nothing is pending.
- **GRANT→IDLE** and **SPUR→IDLE**: always taken on the next clock.

Top module: `irq_agg_top`

## Requirements
- R1: After reset the enable and status registers read zero, `irq_out` is low and `svc_done` is low.
- R2: A source whose level was low at the previous clock edge and is high at this edge sets its status bit, which is visible after this edge. The bit stays set after the source falls.
- R3: A 1 in `st_clr` bit i clears status bit i at the next edge only if source i is low at that edge. If the source is high, the bit stays set, and a rising level in the same cycle wins over the clear.
- R4: `pending` equals `status_q & enable_q`, and `irq_out` is the OR of `pending`. Both follow the registers in the same cycle.
- R5: `en_op` encodes 2'b00 as no change, 2'b01 as setting enable bit `en_sel`, 2'b10 as clearing enable bit `en_sel`, and 2'b11 as loading `en_wdata`. A set or clear leaves all other bits unchanged, and the new value reads back after the edge.
- R6: Bit 3 is reserved. It always reads 0 in `enable_q`, `status_q` and `pending`. A load ignores `en_wdata[3]`, and set or clear with `en_sel` equal to 3, 5, 6 or 7 changes nothing.
- R7: When `svc_req` is sampled high in IDLE and `pending` is non-zero, `svc_done` is high for the next cycle only. In that cycle `svc_spur` is 0 and `svc_idx` is the lowest set pending bit, in the priority order device 0, device 1, device 2, then core (index 4).
- R8: When `svc_req` is sampled high in IDLE with `pending` zero, the next cycle shows `svc_done`=1, `svc_spur`=1 and `svc_idx`=0.
- R9: A request sampled during the reporting cycle is ignored, so the machine returns to IDLE. A request held high therefore yields a report on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | 3 | Device interrupt levels, device i on bit i |
| core_irq | input | 1 | Bridge core interrupt level |
| en_op | input | 2 | Enable register operation |
| en_sel | input | 3 | Source index for set or clear |
| en_wdata | input | 5 | Value for the load operation |
| st_clr | input | 5 | Write-one-to-clear mask for status |
| svc_req | input | 1 | Service request strobe |
| enable_q | output | 5 | Enable register read-back |
| status_q | output | 5 | Status register read-back |
| pending | output | 5 | Status masked by enable |
| irq_out | output | 1 | Combined upstream interrupt level |
| svc_done | output | 1 | Service report valid |
| svc_spur | output | 1 | Report is spurious |
| svc_idx | output | 3 | Reported source index |

## Verification
The bench sweeps all sixteen source patterns against all sixteen enable patterns. A design with a wrong priority chain, a wrong AND mask, or a core index of 3 instead of 4 would report the wrong `svc_idx` or drive the wrong `irq_out`.

Several corner cases get targeted tests. A clear is attempted while the source is still high, which catches a design that drops a live interrupt. A rise and a clear land in the same cycle, which catches a lost edge. A request arrives with nothing pending, which catches a missing spurious flag. The request line is held high, which catches a machine that reports on back-to-back cycles.

Single-bit set and clear operations are swept over all eight index values, including the reserved and out-of-range ones. This catches neighbouring bits being disturbed and bit 3 becoming writable.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [1:0] {
        EN_NOP  = 2'b00,
        EN_SET  = 2'b01,
        EN_CLR  = 2'b10,
        EN_LOAD = 2'b11
    } en_op_e;

    typedef enum logic [1:0] {
        SV_IDLE  = 2'b00,
        SV_GRANT = 2'b01,
        SV_SPUR  = 2'b10
    } svc_state_e;

endpackage

// File: rtl/irq_agg_enable.sv
module irq_agg_enable
    import irq_agg_pkg::*;
#(
    parameter int          W     = 5,
    parameter int          IW    = 3,
    parameter logic [W-1:0] VALID = 5'b10111
) (
    input  logic          clk,
    input  logic          rst_n,
    input  en_op_e        op,
    input  logic [IW-1:0] sel,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  en_q
);

    logic [W-1:0] sel_hot;

    // Decode the index to a one-hot mask, dropping reserved and out-of-range positions.
    always_comb begin
        sel_hot = '0;
        for (int i = 0; i < W; i++) begin
            if (sel == IW'(i)) sel_hot[i] = VALID[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            unique case (op)
                EN_NOP:  en_q <= en_q;
                EN_SET:  en_q <= en_q | sel_hot;
                EN_CLR:  en_q <= en_q & ~sel_hot;
                EN_LOAD: en_q <= wdata & VALID;
            endcase
        end
    end

    // R5: a set reaches the addressed bit
    a_r5_set_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (op == EN_SET) |=> ((en_q & $past(sel_hot)) == $past(sel_hot)));

    // R5: set and clear leave the other bits alone
    a_r5_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op == EN_SET || op == EN_CLR) |=> ((en_q & ~$past(sel_hot)) == ($past(en_q) & ~$past(sel_hot))));

endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
    parameter int           W     = 5,
    parameter logic [W-1:0] VALID = 5'b10111
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic [W-1:0] clr,
    output logic [W-1:0] st_q
);

    logic [W-1:0] src_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_d <= '0;
            st_q  <= '0;
        end else begin
            for (int i = 0; i < W; i++) begin
                if (!VALID[i]) begin
                    src_d[i] <= 1'b0;
                    st_q[i]  <= 1'b0;
                end else begin
                    src_d[i] <= src[i];
                    if (src[i] && !src_d[i])
                        st_q[i] <= 1'b1;
                    else if (clr[i] && !src[i])
                        st_q[i] <= 1'b0;
                end
            end
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_chk
        if (VALID[g]) begin : g_live
            a_r2_rise_latches: assert property (@(posedge clk) disable iff (!rst_n)
                (src[g] && !src_d[g]) |=> st_q[g]);
            a_r3_live_kept: assert property (@(posedge clk) disable iff (!rst_n)
                src[g] |=> st_q[g]);
            a_r3_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[g] && !src[g]) |=> !st_q[g]);
        end
    end

endmodule

// File: rtl/irq_agg_prio.sv
module irq_agg_prio #(
    parameter int W  = 5,
    parameter int IW = 3
) (
    input  logic [W-1:0]  pend,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Scan from the top down so the lowest set bit is the one left in idx.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (pend[i]) idx = IW'(i);
        end
        any = |pend;
    end

endmodule

// File: rtl/irq_agg_svc_fsm.sv
module irq_agg_svc_fsm
    import irq_agg_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          any,
    input  logic [IW-1:0] win_idx,
    output logic          done,
    output logic          spur,
    output logic [IW-1:0] idx
);

    svc_state_e    state_q, state_d;
    logic [IW-1:0] idx_q;

    always_comb begin
        state_d = SV_IDLE;
        unique case (state_q)
            SV_IDLE:  state_d = req ? (any ? SV_GRANT : SV_SPUR) : SV_IDLE;
            SV_GRANT: state_d = SV_IDLE;
            SV_SPUR:  state_d = SV_IDLE;
            default:  state_d = SV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SV_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SV_IDLE && req && any) idx_q <= win_idx;
            else if (state_d == SV_IDLE)          idx_q <= '0;
        end
    end

    always_comb begin
        done = 1'b0;
        spur = 1'b0;
        idx  = '0;
        unique case (state_q)
            SV_IDLE:  ;
            SV_GRANT: begin done = 1'b1; idx = idx_q; end
            SV_SPUR:  begin done = 1'b1; spur = 1'b1; end
            default:  ;
        endcase
    end

    // R9: a report lasts one cycle
    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: an empty request is flagged spurious
    a_r8_empty_spur: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SV_IDLE && req && !any) |=> (done && spur));

    // R7: a request with pending work is granted
    a_r7_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SV_IDLE && req && any) |=> (done && !spur));

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int NDEV     = 3,
    parameter int CORE_POS = 4,
    localparam int W       = CORE_POS + 1,
    localparam int IW      = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NDEV-1:0] dev_irq,
    input  logic          core_irq,
    input  logic [1:0]    en_op,
    input  logic [IW-1:0] en_sel,
    input  logic [W-1:0]  en_wdata,
    input  logic [W-1:0]  st_clr,
    input  logic          svc_req,
    output logic [W-1:0]  enable_q,
    output logic [W-1:0]  status_q,
    output logic [W-1:0]  pending,
    output logic          irq_out,
    output logic          svc_done,
    output logic          svc_spur,
    output logic [IW-1:0] svc_idx
);

    localparam logic [W-1:0] VALID = W'((1 << NDEV) - 1) | (W'(1) << CORE_POS);

    logic [W-1:0]  src;
    logic          any;
    logic [IW-1:0] win_idx;

    always_comb begin
        src                = '0;
        src[NDEV-1:0]      = dev_irq;
        src[CORE_POS]      = core_irq;
    end

    irq_agg_enable #(.W(W), .IW(IW), .VALID(VALID)) u_en (
        .clk(clk), .rst_n(rst_n), .op(en_op_e'(en_op)), .sel(en_sel),
        .wdata(en_wdata), .en_q(enable_q));

    irq_agg_status #(.W(W), .VALID(VALID)) u_st (
        .clk(clk), .rst_n(rst_n), .src(src), .clr(st_clr), .st_q(status_q));

    assign pending = status_q & enable_q;
    assign irq_out = |pending;

    irq_agg_prio #(.W(W), .IW(IW)) u_pr (
        .pend(pending), .any(any), .idx(win_idx));

    irq_agg_svc_fsm #(.IW(IW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(svc_req), .any(any), .win_idx(win_idx),
        .done(svc_done), .spur(svc_spur), .idx(svc_idx));

    // R7: the reported bit was pending and no higher-priority bit was
    a_r7_lowest_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_done && !svc_spur) |->
            ((($past(pending) >> svc_idx) & W'(1)) == W'(1)) &&
            (($past(pending) & ((W'(1) << svc_idx) - W'(1))) == '0));

    // R4: the line drops one cycle after an enable load of zero
    a_r4_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
        (en_op == 2'b11 && en_wdata == '0) |=> !irq_out);

endmodule

// File: tb/sim_irq_agg_top.sv
module sim_irq_agg_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] dev_irq = '0;
    logic       core_irq = 1'b0;
    logic [1:0] en_op = '0;
    logic [2:0] en_sel = '0;
    logic [4:0] en_wdata = '0;
    logic [4:0] st_clr = '0;
    logic       svc_req = 1'b0;
    logic [4:0] enable_q, status_q, pending;
    logic       irq_out, svc_done, svc_spur;
    logic [2:0] svc_idx;

    int checks = 0;
    int fails  = 0;
    bit done_run = 1'b0;

    always #10 clk = ~clk;

    irq_agg_top u0 (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .core_irq(core_irq),
        .en_op(en_op), .en_sel(en_sel), .en_wdata(en_wdata), .st_clr(st_clr),
        .svc_req(svc_req), .enable_q(enable_q), .status_q(status_q),
        .pending(pending), .irq_out(irq_out), .svc_done(svc_done),
        .svc_spur(svc_spur), .svc_idx(svc_idx));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [4:0] spread(input int m);
        return {m[3], 1'b0, m[2:0]};
    endfunction

    function automatic logic [2:0] first_idx(input logic [4:0] p);
        if (p[0]) return 3'd0;
        if (p[1]) return 3'd1;
        if (p[2]) return 3'd2;
        if (p[4]) return 3'd4;
        return 3'd0;
    endfunction

    initial begin
        logic [4:0] s, e, p, acc;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1 enable", enable_q, 0);
        chk("R1 status", status_q, 0);
        chk("R1 irq", irq_out, 0);
        chk("R1 done", svc_done, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 after release", {enable_q, status_q, irq_out, svc_done}, 0);

        for (int m = 0; m < 16; m++) begin
            for (int k = 0; k < 16; k++) begin
                s = spread(m);
                e = spread(k);
                p = s & e;
                dev_irq = 3'b0; core_irq = 1'b0;
                st_clr = 5'h1F; en_op = 2'b11; en_wdata = e | 5'b01000;
                tick();
                st_clr = 5'h00; en_op = 2'b00;
                chk("R5/R6 load readback", enable_q, e);
                chk("R3 clear idle", status_q, 0);
                dev_irq = s[2:0]; core_irq = s[4];
                tick();
                chk("R2 latch", status_q, s);
                chk("R4 pending", pending, p);
                chk("R4 irq_out", irq_out, |p);
                st_clr = 5'h1F;
                tick();
                st_clr = 5'h00;
                chk("R3 clear blocked", status_q, s);
                svc_req = 1'b1;
                tick();
                svc_req = 1'b0;
                chk("R7 done", svc_done, 1);
                chk("R8 spur", svc_spur, (p == 0));
                chk("R7 index", svc_idx, first_idx(p));
                tick();
                chk("R9 one cycle", svc_done, 0);
                dev_irq = 3'b0; core_irq = 1'b0;
                tick();
                chk("R2 sticky", status_q, s);
            end
        end

        // R3: a rise and a clear in the same cycle, the rise wins
        st_clr = 5'h1F; en_op = 2'b11; en_wdata = 5'h17;
        tick();
        st_clr = 5'b00100; en_op = 2'b00; dev_irq = 3'b100;
        tick();
        st_clr = 5'h00;
        chk("R3 rise beats clear", status_q, 5'b00100);

        // R9: a held request reports every other cycle
        dev_irq = 3'b110;
        tick();
        svc_req = 1'b1;
        for (int c = 0; c < 6; c++) begin
            tick();
            chk("R9 held request", svc_done, (c % 2 == 0));
            if (c % 2 == 0) chk("R7 held index", svc_idx, 1);
        end
        svc_req = 1'b0;
        dev_irq = 3'b0;
        tick();
        st_clr = 5'h1F;
        tick();
        st_clr = 5'h00;

        // R5/R6: single-bit set and clear over every index value
        en_op = 2'b11; en_wdata = 5'h00;
        tick();
        acc = 5'h00;
        for (int i = 0; i < 8; i++) begin
            en_op = 2'b01; en_sel = 3'(i);
            tick();
            if (i != 3 && i < 5) acc[i] = 1'b1;
            chk("R5 set bit", enable_q, acc);
            chk("R6 bit3 zero", enable_q[3], 0);
        end
        for (int i = 7; i >= 0; i--) begin
            en_op = 2'b10; en_sel = 3'(i);
            tick();
            if (i != 3 && i < 5) acc[i] = 1'b0;
            chk("R5 clear bit", enable_q, acc);
        end
        en_op = 2'b00;
        tick();
        chk("R5 nop keeps", enable_q, 0);

        done_run = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule